// File: doc/BRIEF.md
# Banked 256-Word Wide RAM Built from 64x1 Slices

This block assembles a 256-word memory of configurable width out of small 64-word, one-bit storage slices. Every data bit is held by a column of four slices, one per bank, and the columns are repeated side by side to make the word as wide as needed. Address, strobe and read/write control are common to every column. Depth comes from decoding the two upper address bits into four bank lines, each gated with the strobe so that only one bank ever sees an active strobe. The lower six address bits go to every slice as the in-bank address.

Each slice behaves like a strobe-gated static cell. A write takes effect on the clock edge where the strobe is high and the read/write select asks for a write. A read first enables the slice output driving zero for one cycle, and only then presents the stored bit. The four bank outputs of each bit would share one wire in a board-level build. Here they are merged by an explicit multiplexer keyed on the bank output enables, and a valid flag marks the cycles in which the merged word carries stored data.

Top module: `wide_bank_ram`

## Requirements
- R1: Address bits [7:6] select one of four banks and bits [5:0] select the word inside that bank; all 256 addresses hold independent words of DATA_W bits.
- R2: On a rising clock edge with strobe high and readNotWrite low (0 = write, 1 = read), wrData is stored at addr.
- R3: On an edge with strobe low, nothing is written, whatever readNotWrite and wrData are. After such an edge, rdData is zero and rdValid is low.
- R4: The first edge of a strobed read to a bank, meaning the previous edge was not a strobed read to that same bank, enables that bank's output. After that edge, rdData is zero and rdValid is low.
- R5: On each following consecutive strobed-read edge to the same bank, the word at the address presented at that edge appears on rdData, with rdValid high, after that edge.
- R6: A strobed read that moves to a different bank restarts the zero-driving phase in the new bank for one edge.
- R7: At most one bank enables its output at any time. When no bank is enabled, rdData is zero and rdValid is low.
- R8: Reading any address leaves the contents of every bank unchanged.
- R9: A write edge enables no bank output. After it, rdData is zero and rdValid is low.
- R10: While rstN is low, all banks are disabled, rdData is zero and rdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (8) | Word address, [7:6] bank, [5:0] in-bank word |
| wrData | input | DATA_W | Data to store on a write edge |
| strobe | input | 1 | Access strobe; no access happens while low |
| readNotWrite | input | 1 | 1 selects read, 0 selects write |
| rdData | output | DATA_W | Merged read word from the enabled bank, zero otherwise |
| rdValid | output | 1 | High when rdData carries stored data |

## Verification
A write lands on the edge that samples it. The results of every edge (output enable, zero phase or data) are due on rdData and rdValid right after that same edge. A read that starts a burst or changes bank therefore shows valid data only one edge later than a read that continues in the same bank. The reference model in the bench is updated on each rising edge from the inputs it drives, and the ports are compared against it on every falling edge, so each check samples the result of exactly the preceding edge. Reads issued in random order, per-bank bursts, alternating banks and a full re-read after all of them cover both the latency cases and the no-disturb property.

// File: rtl/wide_bank_ram_pkg.sv
package wide_bank_ram_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_SEL_W = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_VALID = 2'd2
  } slice_phase_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankStb;
    logic                 readMode;
  } bank_ctrl_t;
endpackage

// File: rtl/ram_bit_slice.sv
module ram_bit_slice
  import wide_bank_ram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sliceStb,
  input  logic          readMode,
  input  logic [AW-1:0] sliceAddr,
  input  logic          din,
  output logic          dout,
  output logic          outEn,
  output logic          dataValid
);
  localparam int WORDS = 1 << AW;

  logic         store [WORDS];
  slice_phase_t phase;
  logic         dataQ;

  // storage cell array: written only on a strobed write edge
  always_ff @(posedge clk) begin
    if (sliceStb && !readMode) store[sliceAddr] <= din;
  end

  // read sequencing: idle -> driven low -> valid while the read is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      dataQ <= 1'b0;
    end else if (!(sliceStb && readMode)) begin
      phase <= PH_IDLE;
      dataQ <= 1'b0;
    end else if (phase == PH_IDLE) begin
      phase <= PH_LOW;
      dataQ <= 1'b0;
    end else begin
      phase <= PH_VALID;
      dataQ <= store[sliceAddr];
    end
  end

  assign outEn     = (phase != PH_IDLE);
  assign dataValid = (phase == PH_VALID);
  assign dout      = dataValid & dataQ;
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import wide_bank_ram_pkg::*;
(
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic                  strobe,
  input  logic                  readNotWrite,
  output bank_ctrl_t            ctrlS
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign ctrlS.bankStb[b] = strobe && (bankSel == BANK_SEL_W'(b));
  end
  assign ctrlS.readMode = readNotWrite;
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import wide_bank_ram_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLICE_AW = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bank_ctrl_t           ctrlS,
  input  logic [SLICE_AW-1:0]  sliceAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [NUM_BANKS-1:0] bankOutEn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);
  logic [NUM_BANKS-1:0][DATA_W-1:0] bankDout;
  logic [NUM_BANKS-1:0][DATA_W-1:0] enBits;
  logic [NUM_BANKS-1:0][DATA_W-1:0] vldBits;
  logic [NUM_BANKS-1:0]             bankValid;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      ram_bit_slice #(.AW(SLICE_AW)) u_slice (
        .clk      (clk),
        .rstN     (rstN),
        .sliceStb (ctrlS.bankStb[b]),
        .readMode (ctrlS.readMode),
        .sliceAddr(sliceAddr),
        .din      (wrData[i]),
        .dout     (bankDout[b][i]),
        .outEn    (enBits[b][i]),
        .dataValid(vldBits[b][i])
      );
    end
    // all slices of a bank share controls, so their enables agree
    assign bankOutEn[b] = &enBits[b];
    assign bankValid[b] = &vldBits[b];
  end

  // shared-line resolver: pass the enabled bank, zero when none drives
  always_comb begin
    rdData  = '0;
    rdValid = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankOutEn[b]) begin
        rdData  = bankDout[b];
        rdValid = bankValid[b];
      end
    end
  end
endmodule

// File: rtl/wide_bank_ram.sv
module wide_bank_ram
  import wide_bank_ram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              strobe,
  input  logic              readNotWrite,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int SLICE_AW = ADDR_W - BANK_SEL_W;

  bank_ctrl_t           ctrlS;
  logic [NUM_BANKS-1:0] bankOutEn;

  bank_ctrl u_ctrl (
    .bankSel     (addr[ADDR_W-1 -: BANK_SEL_W]),
    .strobe      (strobe),
    .readNotWrite(readNotWrite),
    .ctrlS       (ctrlS)
  );

  bank_datapath #(.DATA_W(DATA_W), .SLICE_AW(SLICE_AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlS    (ctrlS),
    .sliceAddr(addr[SLICE_AW-1:0]),
    .wrData   (wrData),
    .bankOutEn(bankOutEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );
endmodule

// File: rtl/wide_bank_ram_chk.sv
module wide_bank_ram_chk
  import wide_bank_ram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic                 strobe,
  input logic                 readNotWrite,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdValid,
  input logic [NUM_BANKS-1:0] bankOutEn
);
  assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankOutEn));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> (bankOutEn == '0) && (rdData == '0) && !rdValid);

  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !readNotWrite) |=> (bankOutEn == '0) && !rdValid);

  assert_low_phase_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  assert_valid_needs_held_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(strobe && readNotWrite) && $past(strobe && readNotWrite, 2)
                 && ($past(addr[ADDR_W-1 -: BANK_SEL_W]) == $past(addr[ADDR_W-1 -: BANK_SEL_W], 2))));

  assert_read_enables_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && readNotWrite) |=> $countones(bankOutEn) == 1);
endmodule

bind wide_bank_ram wide_bank_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .strobe      (strobe),
  .readNotWrite(readNotWrite),
  .rdData      (rdData),
  .rdValid     (rdValid),
  .bankOutEn   (bankOutEn)
);

// File: tb/wide_bank_ram_test.sv
module wide_bank_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   addr = '0;
  logic [N-1:0] wrData = '0;
  logic         strobe = 1'b0;
  logic         readNotWrite = 1'b0;
  logic [N-1:0] rdData;
  logic         rdValid;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  // reference model state
  logic [N-1:0] model [256];
  int           prevBank = -1;
  logic [N-1:0] expData = '0;
  logic         expValid = 1'b0;

  wide_bank_ram #(.DATA_W(N), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .strobe(strobe), .readNotWrite(readNotWrite),
    .rdData(rdData), .rdValid(rdValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBank = -1;
      expData  = '0;
      expValid = 1'b0;
    end else if (strobe && readNotWrite) begin
      if (prevBank == int'(addr[7:6])) begin
        expValid = 1'b1;
        expData  = model[addr];
      end else begin
        expValid = 1'b0;
        expData  = '0;
      end
      prevBank = int'(addr[7:6]);
    end else begin
      prevBank = -1;
      expValid = 1'b0;
      expData  = '0;
      if (strobe) model[addr] = wrData;
    end
  end

  function automatic logic [N-1:0] pat(input int a, input int salt);
    int v;
    v = a * 29 + 91 + salt;
    return v[N-1:0];
  endfunction

  task automatic check(input string tag);
    checks++;
    if (rdData !== expData) begin
      errors++;
      $display("FAIL %s rdData=%h expected %h (addr %0d)", tag, rdData, expData, addr);
    end
    checks++;
    if (rdValid !== expValid) begin
      errors++;
      $display("FAIL %s rdValid=%b expected %b (addr %0d)", tag, rdValid, expValid, addr);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input int a, input logic [N-1:0] d,
                     input string tag);
    strobe = s; readNotWrite = r; addr = a[7:0]; wrData = d;
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    int perm [256];
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10");
    rstN = 1'b1;
    @(negedge clk);
    check("R10");

    // R2 / R9: fill every address with a distinct word
    for (int a = 0; a < 256; a++) cyc(1, 0, a, pat(a, 0), "R2_R9");

    // R3: unstrobed writes and reads must not change anything
    for (int a = 0; a < 256; a += 3) cyc(0, 0, a, ~pat(a, 0), "R3");
    for (int a = 0; a < 16; a++) cyc(0, 1, a * 16, '0, "R3");

    // R1 / R5: per-bank bursts in address order
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 64; w++) cyc(1, 1, b * 64 + w, '0, "R1_R5");
    cyc(0, 1, 0, '0, "R3");

    // R4: isolated reads, each a fresh start, then held once
    for (int a = 5; a < 256; a += 37) begin
      cyc(1, 1, a, '0, "R4");
      cyc(1, 1, a, '0, "R5");
      cyc(0, 0, a, '0, "R7");
    end

    // R6 / R7: bank changes every edge and every second edge
    for (int k = 0; k < 64; k++) cyc(1, 1, (k % 4) * 64 + k, '0, "R6_R7");
    for (int k = 0; k < 64; k++) cyc(1, 1, ((k / 2) % 4) * 64 + k, '0, "R6");
    cyc(0, 0, 0, '0, "R7");

    // R8: random-order read of all addresses, then a full ordered re-read
    for (int i = 0; i < 256; i++) perm[i] = i;
    for (int i = 255; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < 256; i++) begin
      cyc(1, 1, perm[i], '0, "R8");
      if (i % 5 == 0) cyc(1, 1, perm[i], '0, "R8");
    end
    cyc(0, 1, 0, '0, "R3");
    for (int a = 0; a < 256; a++) begin
      cyc(1, 1, a, '0, "R8");
      cyc(1, 1, a, '0, "R8");
    end

    // R2: overwrite one bank, confirm neighbours keep their data
    for (int w = 0; w < 64; w++) cyc(1, 0, 128 + w, pat(w, 77), "R2");
    for (int a = 0; a < 256; a++) cyc(1, 1, a, '0, "R2_R1");
    cyc(0, 0, 0, '0, "R7");

    done = 1;
    finish_run();
  end
endmodule